// File: doc/BRIEF.md
# Test Vector Pin-Code Engine

This block runs one test case for a chip sitting in a socket of up to `NPINS` pins. A test case arrives as ASCII characters, one per cycle on a valid/ready input stream. Each accepted character that is a pin code is assigned to the next pin, starting at pin 1. A separator character is dropped, and a line feed closes the case. Pins that received no code are treated as unused, and an unused pin is expected to float. The engine then works through the pins in three ordered passes over an external probe port. The first pass applies every drive. The second pulses every clock pin. The third senses every pin that carries an expectation or a probe.

When the case is finished, the engine sends one result character per pin on a valid/ready output stream, with pin 1 first, followed by a line feed. A pass flag reports whether every expectation matched. An error flag reports a malformed case. A malformed case is discarded up to its line feed and produces no probing and no result. The probe port works one request at a time. The engine raises a request carrying an operation and a 0-based pin index. The external probe logic answers with a single-cycle acknowledge and one sensed level. Drive operations persist on the pin until another operation replaces them.

Back-pressure rules: an input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from the accepted line feed of a good case until the result line feed has been taken. On the output side, `res_data` holds its value while `res_valid` is high and `res_ready` is low.

Top module: `tvpe_engine`

## Requirements
- R1: `in_ready` is high while the engine collects or discards a case. It is low whenever a probe request is pending or a result character is offered. A byte transfers only on an edge where `in_valid` and `in_ready` are both high.
- R2: Pin codes are assigned in stream order, starting at pin 1 (probe index 0, result position 0). The character '/' (0x2F) is discarded and does not advance the pin position.
- R3: A pin with no received code, or with the code 'u', expects a floating pin. It reports '.' when floating, otherwise 'H' or 'L'.
- R4: The drive pass visits pins in ascending order. 'V' and '1' issue op 1 (drive high). 'G', '0' and 'C' issue op 0 (drive low). 'X' issues op 5 (weak pull-down). The drive pass and the clock pass complete before any sensing op (2, 3 or 4) is issued.
- R5: After the drive pass, each 'C' pin in ascending order receives op 1 and then op 0. This completes before sensing starts.
- R6: Each 'L', 'H', 'Z' or unused pin receives op 2 (pull up) and then op 3 (pull down). The pin is classed high if both sensed levels are 1, low if both are 0, and floating otherwise. It reports '.' when the class matches the code, otherwise 'H', 'L' or 'Z' for the class found.
- R7: A '?' pin is classed with the same two operations and reports '1', '0' or 'Z'. An 'S' pin receives a single op 4 (sample) and reports '1' or '0' from the sensed level.
- R8: Pins coded 'V', 'G', '1', '0', 'C' or 'X' report '_'.
- R9: A result is `NPINS` characters, pin 1 first, followed by 0x0A. `res_data` is stable while `res_valid` is high and `res_ready` is low.
- R10: A character that is not a code, a separator or a line feed sets `case_err` at once. So does a code beyond pin `NPINS`. The rest of the case, up to its line feed, is then consumed with no probe request and no result.
- R11: `case_pass` rises on the edge where the result line feed is taken, if every 'L', 'H', 'Z' and unused pin reported '.'. Both `case_pass` and `case_err` clear when the first byte of the next case is taken. They are never high together.
- R12: A probe request holds `prb_op` and `prb_pin` stable until `prb_ack` is seen. `prb_level` is read only on the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Engine accepts a character |
| in_data | input | 8 | ASCII character of the test case |
| res_valid | output | 1 | Result character valid |
| res_ready | input | 1 | Consumer takes the result character |
| res_data | output | 8 | ASCII result character |
| prb_req | output | 1 | Probe request pending |
| prb_op | output | 3 | Probe operation (0..5, see R4-R7) |
| prb_pin | output | $clog2(NPINS) | 0-based pin index of the request |
| prb_ack | input | 1 | Probe done, one cycle |
| prb_level | input | 1 | Sensed pin level, valid with `prb_ack` |
| case_pass | output | 1 | Last case met every expectation |
| case_err | output | 1 | Current or last case was malformed |

## Verification
The hardest situation to reach is the interplay of passes within a single case. Clock pins must be pulsed strictly after every drive, and an unused tail must be probed for float, all while both streams stall and the probe port answers late. The stimulus reaches this with random cases that mix every code, scatter separators, vary length from empty to full, and give each socket pin a random behaviour (driving low, driving high, or floating with random residual charge). A responder acknowledges after random delays, and the result consumer withdraws ready at random. Directed cases add the empty line, a full row of clock and probe codes, an illegal character, and a 25th code, each followed by a good case to observe the flags clearing.

// File: rtl/tvpe_pkg.sv
package tvpe_pkg;

  typedef enum logic [3:0] {
    PC_VCC, PC_GND, PC_HI, PC_LO, PC_CLK,
    PC_EXP_L, PC_EXP_H, PC_EXP_Z,
    PC_DONT, PC_EXPLORE, PC_SAMPLE, PC_UNUSED
  } pin_code_e;

  typedef enum logic [2:0] {
    OP_DRIVE_LO = 3'd0,
    OP_DRIVE_HI = 3'd1,
    OP_PULL_UP  = 3'd2,
    OP_PULL_DN  = 3'd3,
    OP_SAMPLE   = 3'd4,
    OP_WEAK_DN  = 3'd5
  } probe_op_e;

  typedef enum logic [1:0] {OBS_LOW, OBS_HIGH, OBS_Z} obs_e;

  typedef enum logic [1:0] {PH_IDLE, PH_DRIVE, PH_CLOCK, PH_PROBE} seq_phase_e;

  typedef enum logic [1:0] {T_RX, T_SKIP, T_RUN, T_EMIT} top_state_e;

  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_SEP = 8'h2F;

  function automatic logic [7:0] obs_letter(obs_e o);
    case (o)
      OBS_LOW:  return "L";
      OBS_HIGH: return "H";
      default:  return "Z";
    endcase
  endfunction

  function automatic logic is_expect(pin_code_e c);
    return (c == PC_EXP_L) || (c == PC_EXP_H) || (c == PC_EXP_Z) || (c == PC_UNUSED);
  endfunction

endpackage

// File: rtl/tvpe_code_decode.sv
module tvpe_code_decode
  import tvpe_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_code,
  output logic       is_sep,
  output logic       is_eol,
  output pin_code_e  code
);
  always_comb begin
    is_code = 1'b1;
    is_sep  = (ch == CH_SEP);
    is_eol  = (ch == CH_LF);
    code    = PC_UNUSED;
    case (ch)
      "V":     code = PC_VCC;
      "G":     code = PC_GND;
      "1":     code = PC_HI;
      "0":     code = PC_LO;
      "C":     code = PC_CLK;
      "L":     code = PC_EXP_L;
      "H":     code = PC_EXP_H;
      "Z":     code = PC_EXP_Z;
      "X":     code = PC_DONT;
      "?":     code = PC_EXPLORE;
      "S":     code = PC_SAMPLE;
      "u":     code = PC_UNUSED;
      default: is_code = 1'b0;
    endcase
  end
endmodule

// File: rtl/tvpe_result_enc.sv
module tvpe_result_enc
  import tvpe_pkg::*;
(
  input  pin_code_e  code,
  input  obs_e       obs,
  output logic [7:0] ch,
  output logic       ok
);
  logic match;

  always_comb begin
    case (code)
      PC_EXP_L:             match = (obs == OBS_LOW);
      PC_EXP_H:             match = (obs == OBS_HIGH);
      PC_EXP_Z, PC_UNUSED:  match = (obs == OBS_Z);
      default:              match = 1'b0;
    endcase
  end

  always_comb begin
    case (code)
      PC_EXP_L, PC_EXP_H, PC_EXP_Z, PC_UNUSED:
        ch = match ? "." : obs_letter(obs);
      PC_EXPLORE:
        ch = (obs == OBS_HIGH) ? "1" : (obs == OBS_LOW) ? "0" : "Z";
      PC_SAMPLE:
        ch = (obs == OBS_HIGH) ? "1" : "0";
      default:
        ch = "_";
    endcase
  end

  assign ok = !is_expect(code) || match;
endmodule

// File: rtl/tvpe_pin_bank.sv
module tvpe_pin_bank
  import tvpe_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PW    = $clog2(NPINS),
  parameter int CW    = $clog2(NPINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  pin_code_e        wr_code,
  input  logic [CW-1:0]    fill_cnt,
  input  logic             obs_we,
  input  logic [PW-1:0]    obs_idx,
  input  obs_e             obs_val,
  output pin_code_e        eff_code [NPINS],
  output logic [7:0]       res_char [NPINS],
  output logic [NPINS-1:0] pin_ok
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_code_e code_q;
    obs_e      obs_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q <= PC_UNUSED;
        obs_q  <= OBS_Z;
      end else begin
        if (wr_en && wr_idx == PW'(g)) code_q <= wr_code;
        if (obs_we && obs_idx == PW'(g)) obs_q <= obs_val;
      end
    end

    assign eff_code[g] = (CW'(g) < fill_cnt) ? code_q : PC_UNUSED;

    tvpe_result_enc u_enc (
      .code (eff_code[g]),
      .obs  (obs_q),
      .ch   (res_char[g]),
      .ok   (pin_ok[g])
    );
  end
endmodule

// File: rtl/tvpe_probe_seq.sv
module tvpe_probe_seq
  import tvpe_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PW    = $clog2(NPINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pin_code_e     codes [NPINS],
  output logic          req,
  output probe_op_e     op,
  output logic [PW-1:0] pin,
  input  logic          ack,
  input  logic          level,
  output logic          obs_we,
  output logic [PW-1:0] obs_idx,
  output obs_e          obs_val,
  output logic          done
);
  seq_phase_e    phase_q;
  logic [PW-1:0] pin_q;
  logic          step_q, req_q, up_q;
  probe_op_e     op_q;

  pin_code_e cur;
  logic      need, last, adv, at_end;
  probe_op_e nop;

  always_comb begin
    cur = PC_UNUSED;
    for (int i = 0; i < NPINS; i++)
      if (pin_q == PW'(i)) cur = codes[i];
  end

  always_comb begin
    need = 1'b0;
    last = 1'b1;
    nop  = OP_DRIVE_LO;
    case (phase_q)
      PH_DRIVE: begin
        need = cur inside {PC_VCC, PC_GND, PC_HI, PC_LO, PC_CLK, PC_DONT};
        nop  = (cur == PC_VCC || cur == PC_HI) ? OP_DRIVE_HI :
               (cur == PC_DONT) ? OP_WEAK_DN : OP_DRIVE_LO;
      end
      PH_CLOCK: begin
        need = (cur == PC_CLK);
        nop  = step_q ? OP_DRIVE_LO : OP_DRIVE_HI;
        last = step_q;
      end
      PH_PROBE: begin
        need = cur inside {PC_EXP_L, PC_EXP_H, PC_EXP_Z, PC_UNUSED, PC_EXPLORE, PC_SAMPLE};
        nop  = (cur == PC_SAMPLE) ? OP_SAMPLE : (step_q ? OP_PULL_DN : OP_PULL_UP);
        last = (cur == PC_SAMPLE) || step_q;
      end
      default: need = 1'b0;
    endcase
  end

  assign at_end = (pin_q == PW'(NPINS - 1));
  assign adv    = (phase_q != PH_IDLE) && (req_q ? (ack && last) : !need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pin_q   <= '0;
      step_q  <= 1'b0;
      req_q   <= 1'b0;
      up_q    <= 1'b0;
      op_q    <= OP_DRIVE_LO;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start) begin
          phase_q <= PH_DRIVE;
          pin_q   <= '0;
          step_q  <= 1'b0;
        end
      end else begin
        if (req_q) begin
          if (ack) begin
            req_q <= 1'b0;
            if (!last) begin
              step_q <= 1'b1;
              up_q   <= level;
            end else begin
              step_q <= 1'b0;
            end
          end
        end else if (need) begin
          req_q <= 1'b1;
          op_q  <= nop;
        end
        if (adv) begin
          if (at_end) begin
            pin_q <= '0;
            case (phase_q)
              PH_DRIVE: phase_q <= PH_CLOCK;
              PH_CLOCK: phase_q <= PH_PROBE;
              default: begin
                phase_q <= PH_IDLE;
                done    <= 1'b1;
              end
            endcase
          end else begin
            pin_q <= pin_q + 1'b1;
          end
        end
      end
    end
  end

  assign req     = req_q;
  assign op      = op_q;
  assign pin     = pin_q;
  assign obs_we  = (phase_q == PH_PROBE) && req_q && ack && last;
  assign obs_idx = pin_q;

  always_comb begin
    if (cur == PC_SAMPLE)      obs_val = level ? OBS_HIGH : OBS_LOW;
    else if (up_q && level)    obs_val = OBS_HIGH;
    else if (!up_q && !level)  obs_val = OBS_LOW;
    else                       obs_val = OBS_Z;
  end

  // R12: a pending request keeps its operation and pin until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(op_q) && $stable(pin_q)));

  // R6: an observation is only recorded on the answer to a sensing op
  p_obs_from_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    obs_we |-> (op_q == OP_PULL_DN || op_q == OP_SAMPLE));

  // R5: the high half of a clock pulse is followed by the low half on the same pin
  p_clock_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack && op_q == OP_DRIVE_HI && phase_q == PH_CLOCK)
      |-> ##2 (req_q && op_q == OP_DRIVE_LO && pin_q == $past(pin_q, 2)));

endmodule

// File: rtl/tvpe_engine.sv
module tvpe_engine
  import tvpe_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [7:0]                 res_data,
  output logic                       prb_req,
  output logic [2:0]                 prb_op,
  output logic [$clog2(NPINS)-1:0]   prb_pin,
  input  logic                       prb_ack,
  input  logic                       prb_level,
  output logic                       case_pass,
  output logic                       case_err
);
  localparam int PW = $clog2(NPINS);
  localparam int CW = $clog2(NPINS + 1);

  top_state_e    st_q;
  logic [CW-1:0] cnt_q, eidx_q;
  logic          fresh_q, pass_q, err_q, sense_seen_q;

  logic      is_code, is_sep, is_eol, acc, wr_en, seq_start, seq_done;
  pin_code_e dec_code;
  pin_code_e eff_code [NPINS];
  logic [7:0] res_char [NPINS];
  logic [NPINS-1:0] pin_ok;
  logic          obs_we;
  logic [PW-1:0] obs_idx;
  obs_e          obs_val;
  probe_op_e     seq_op;

  tvpe_code_decode u_dec (
    .ch      (in_data),
    .is_code (is_code),
    .is_sep  (is_sep),
    .is_eol  (is_eol),
    .code    (dec_code)
  );

  assign in_ready  = (st_q == T_RX) || (st_q == T_SKIP);
  assign acc       = in_valid && in_ready;
  assign wr_en     = acc && (st_q == T_RX) && is_code && (cnt_q < CW'(NPINS));
  assign seq_start = acc && (st_q == T_RX) && is_eol;

  tvpe_pin_bank #(.NPINS(NPINS), .PW(PW), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (cnt_q[PW-1:0]),
    .wr_code  (dec_code),
    .fill_cnt (cnt_q),
    .obs_we   (obs_we),
    .obs_idx  (obs_idx),
    .obs_val  (obs_val),
    .eff_code (eff_code),
    .res_char (res_char),
    .pin_ok   (pin_ok)
  );

  tvpe_probe_seq #(.NPINS(NPINS), .PW(PW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (seq_start),
    .codes   (eff_code),
    .req     (prb_req),
    .op      (seq_op),
    .pin     (prb_pin),
    .ack     (prb_ack),
    .level   (prb_level),
    .obs_we  (obs_we),
    .obs_idx (obs_idx),
    .obs_val (obs_val),
    .done    (seq_done)
  );

  assign prb_op = seq_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= T_RX;
      cnt_q   <= '0;
      eidx_q  <= '0;
      fresh_q <= 1'b1;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        T_RX: if (acc) begin
          if (fresh_q) begin
            pass_q  <= 1'b0;
            err_q   <= 1'b0;
            fresh_q <= 1'b0;
          end
          if (is_eol) begin
            st_q <= T_RUN;
          end else if (is_sep) begin
            st_q <= T_RX;
          end else if (is_code && cnt_q < CW'(NPINS)) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            err_q <= 1'b1;
            st_q  <= T_SKIP;
          end
        end
        T_SKIP: if (acc && is_eol) begin
          st_q    <= T_RX;
          cnt_q   <= '0;
          fresh_q <= 1'b1;
        end
        T_RUN: if (seq_done) begin
          st_q   <= T_EMIT;
          eidx_q <= '0;
        end
        default: if (res_ready) begin
          if (eidx_q == CW'(NPINS)) begin
            pass_q  <= &pin_ok;
            st_q    <= T_RX;
            cnt_q   <= '0;
            fresh_q <= 1'b1;
          end else begin
            eidx_q <= eidx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign res_valid = (st_q == T_EMIT);

  always_comb begin
    res_data = CH_LF;
    for (int i = 0; i < NPINS; i++)
      if (eidx_q == CW'(i)) res_data = res_char[i];
  end

  assign case_pass = pass_q;
  assign case_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          sense_seen_q <= 1'b0;
    else if (seq_start)  sense_seen_q <= 1'b0;
    else if (prb_req && (seq_op == OP_PULL_UP || seq_op == OP_PULL_DN || seq_op == OP_SAMPLE))
      sense_seen_q <= 1'b1;
  end

  // R4: once sensing has begun in a case, no drive operation follows
  p_drive_before_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_seen_q && prb_req) |-> (prb_op inside {3'd2, 3'd3, 3'd4}));

  // R1: no input accepted while probing or emitting
  p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_req || res_valid) |-> !in_ready);

  // R9: offered result character stays put under back-pressure
  p_res_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R10: an aborted case never probes nor emits
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    case_err |-> (!prb_req && !res_valid));

  // R11: pass and error are exclusive
  p_pass_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(case_pass && case_err));

endmodule

// File: tb/tvpe_engine_test.sv
module tvpe_engine_test;
  localparam int NPINS = 24;
  localparam int PW    = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic res_ready = 1'b0;
  logic prb_ack = 1'b0;
  logic prb_level = 1'b0;
  logic in_ready, res_valid, prb_req, case_pass, case_err;
  logic [7:0] res_data;
  logic [2:0] prb_op;
  logic [PW-1:0] prb_pin;

  always #10 clk = ~clk;

  tvpe_engine #(.NPINS(NPINS)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .prb_req(prb_req), .prb_op(prb_op), .prb_pin(prb_pin),
    .prb_ack(prb_ack), .prb_level(prb_level),
    .case_pass(case_pass), .case_err(case_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] stm [0:79];
  int stm_n;
  logic [7:0] ec [0:NPINS-1];
  int beh [0:NPINS-1];      // 0 drives low, 1 drives high, 2 floats
  bit charge [0:NPINS-1];

  int got_n;
  logic [2:0] got_op [0:255];
  int got_pin [0:255];
  int exp_n;
  logic [2:0] exp_op [0:255];
  int exp_pin [0:255];

  bit res_seen;
  int rdy_bad, res_bad, prb_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  // probe responder
  initial begin
    forever begin
      @(negedge clk);
      prb_ack = 1'b0;
      if (prb_req) begin
        int p, op;
        p  = int'(prb_pin);
        op = int'(prb_op);
        if (got_n < 256) begin
          got_op[got_n]  = prb_op;
          got_pin[got_n] = p;
        end
        got_n++;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (beh[p] < 2)    prb_level = (beh[p] == 1);
        else if (op == 2)  prb_level = 1'b1;
        else if (op == 3)  prb_level = 1'b0;
        else               prb_level = charge[p];
        prb_ack = 1'b1;
      end
    end
  end

  // handshake monitors
  initial begin
    logic [7:0] pd;
    logic [2:0] po;
    logic [PW-1:0] pp;
    bit hold_r, hold_p;
    hold_r = 0; hold_p = 0;
    forever begin
      @(negedge clk);
      if (res_valid) res_seen = 1;
      if (in_ready && (res_valid || prb_req)) rdy_bad++;
      if (hold_r && (!res_valid || res_data != pd)) res_bad++;
      if (hold_p && (!prb_req || prb_op != po || prb_pin != pp)) prb_bad++;
      #1;
      hold_r = res_valid && !res_ready;  pd = res_data;
      hold_p = prb_req && !prb_ack;      po = prb_op; pp = prb_pin;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1: actual hung expected case completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [7:0] exp_char(logic [7:0] c, int b, bit q);
    logic [7:0] ol;
    ol = (b == 0) ? "L" : (b == 1) ? "H" : "Z";
    case (c)
      "L": return (b == 0) ? "." : ol;
      "H": return (b == 1) ? "." : ol;
      "Z", "u": return (b == 2) ? "." : ol;
      "?": return (b == 0) ? "0" : (b == 1) ? "1" : "Z";
      "S": return (b < 2) ? ((b == 1) ? "1" : "0") : (q ? "1" : "0");
      default: return "_";
    endcase
  endfunction

  task automatic push_op(input int op, input int p);
    exp_op[exp_n] = 3'(op); exp_pin[exp_n] = p; exp_n++;
  endtask

  task automatic build_exp_ops();
    exp_n = 0;
    for (int i = 0; i < NPINS; i++)
      case (ec[i])
        "V", "1": push_op(1, i);
        "G", "0", "C": push_op(0, i);
        "X": push_op(5, i);
        default: ;
      endcase
    for (int i = 0; i < NPINS; i++)
      if (ec[i] == "C") begin push_op(1, i); push_op(0, i); end
    for (int i = 0; i < NPINS; i++)
      case (ec[i])
        "S": push_op(4, i);
        "L", "H", "Z", "u", "?": begin push_op(2, i); push_op(3, i); end
        default: ;
      endcase
  endtask

  task automatic randomize_pins(input bit make_pass);
    for (int i = 0; i < NPINS; i++) begin
      beh[i] = $urandom_range(0, 2);
      charge[i] = 1'($urandom_range(0, 1));
      if (make_pass)
        case (ec[i])
          "L": beh[i] = 0;
          "H": beh[i] = 1;
          "Z", "u": beh[i] = 2;
          default: ;
        endcase
    end
  endtask

  task automatic set_stream(input string s);
    int k;
    k = 0;
    stm_n = 0;
    for (int i = 0; i < NPINS; i++) ec[i] = "u";
    for (int i = 0; i < s.len(); i++) begin
      stm[stm_n] = s[i]; stm_n++;
      if (s[i] != "/" && s[i] != 8'h0A && k < NPINS) begin ec[k] = s[i]; k++; end
    end
  endtask

  task automatic build_random();
    string alpha;
    int k;
    alpha = "VG10CLHZX?Su";
    k = $urandom_range(0, NPINS);
    stm_n = 0;
    for (int i = 0; i < NPINS; i++) ec[i] = "u";
    for (int i = 0; i < k; i++) begin
      if ($urandom_range(0, 4) == 0) begin stm[stm_n] = "/"; stm_n++; end
      ec[i] = alpha[$urandom_range(0, 11)];
      stm[stm_n] = ec[i]; stm_n++;
    end
    if ($urandom_range(0, 2) == 0) begin stm[stm_n] = "/"; stm_n++; end
    stm[stm_n] = 8'h0A; stm_n++;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input bit exp_err);
    logic [7:0] got [0:NPINS];
    bit ok, exp_pass;
    int i;
    got_n = 0; res_seen = 0; rdy_bad = 0; res_bad = 0; prb_bad = 0;
    for (int j = 0; j < stm_n; j++) send_byte(stm[j]);
    if (exp_err) begin
      repeat (60) @(negedge clk);
      chk(case_err == 1'b1, "R10", "error flag", $sformatf("%0b", case_err), "1");
      chk(got_n == 0 && !res_seen, "R10", "aborted case quiet",
          $sformatf("ops=%0d res=%0b", got_n, res_seen), "ops=0 res=0");
      chk(case_pass == 1'b0, "R11", "pass low on error", $sformatf("%0b", case_pass), "0");
      return;
    end
    i = 0;
    while (i < NPINS + 1) begin
      @(negedge clk);
      res_ready = ($urandom_range(0, 2) != 0);
      if (res_valid && res_ready) begin got[i] = res_data; i++; end
    end
    @(negedge clk);
    res_ready = 1'b0;
    ok = 1; exp_pass = 1;
    for (int j = 0; j < NPINS; j++) begin
      logic [7:0] e;
      e = exp_char(ec[j], beh[j], charge[j]);
      if (got[j] != e) begin
        ok = 0;
        $display("  pin %0d code %s got %s exp %s", j + 1, ec[j], got[j], e);
      end
      if ((ec[j] == "L" || ec[j] == "H" || ec[j] == "Z" || ec[j] == "u") && e != ".") exp_pass = 0;
    end
    // R2 R3 R6 R7 R8: per-pin characters; R9: trailing line feed
    chk(ok, "R2", "R3 R6 R7 R8 result characters", "see pin lines", "per-pin model");
    chk(got[NPINS] == 8'h0A, "R9", "terminator", $sformatf("%h", got[NPINS]), "0a");
    build_exp_ops();
    ok = (got_n == exp_n);
    for (int j = 0; j < exp_n && j < got_n; j++)
      if (got_op[j] != exp_op[j] || got_pin[j] != exp_pin[j]) ok = 0;
    // R4 R5: drive pass, then clock pulses, then sensing
    chk(ok, "R4", "R5 probe op sequence", $sformatf("%0d ops", got_n), $sformatf("%0d ops", exp_n));
    chk(case_pass == exp_pass, "R11", "pass flag", $sformatf("%0b", case_pass), $sformatf("%0b", exp_pass));
    chk(case_err == 1'b0, "R11", "error cleared", $sformatf("%0b", case_err), "0");
    chk(rdy_bad == 0, "R1", "in_ready while busy", $sformatf("%0d", rdy_bad), "0");
    chk(res_bad == 0, "R9", "result hold", $sformatf("%0d", res_bad), "0");
    chk(prb_bad == 0, "R12", "probe hold", $sformatf("%0d", prb_bad), "0");
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NPINS; i++) begin beh[i] = 2; charge[i] = 0; end
    got_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !res_valid && !prb_req && !case_pass && !case_err, "R1",
        "reset state", $sformatf("%b%b%b%b%b", in_ready, res_valid, prb_req, case_pass, case_err), "10000");

    // empty case: every pin unused and floating (R3)
    set_stream("\n"); randomize_pins(1'b1); run_case(1'b0);
    // unused pins driven by the chip (R3 mismatches)
    set_stream("LH\n"); randomize_pins(1'b0); beh[5] = 0; beh[9] = 1; run_case(1'b0);
    // heavy separators (R2)
    set_stream("//V/1/0/G//C/L/H/Z/X/?/S/\n"); randomize_pins(1'b0); run_case(1'b0);
    // illegal character (R10), then good case clears flag (R11)
    set_stream("10Q1/H\n"); run_case(1'b1);
    set_stream("1L0H\n"); randomize_pins(1'b1); run_case(1'b0);
    // 25 codes overflow (R10)
    set_stream("1111111111111111111111111\n"); run_case(1'b1);
    // full row of probes and clocks (R5, R7)
    set_stream("????????????????????????\n"); randomize_pins(1'b0); run_case(1'b0);
    set_stream("CC1CLLCSSG0VCCCCCCCCCCCC\n"); randomize_pins(1'b0); run_case(1'b0);

    for (int n = 0; n < 40; n++) begin
      build_random();
      randomize_pins($urandom_range(0, 2) == 0);
      run_case(1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule